// File: doc/BRIEF.md
# Wakeup-Select Issue Queue

This block holds renamed instructions that are waiting for their source operands. Each instruction arrives in program order with two source tags, a ready flag for each source, a destination tag and an opaque operation field. A result-tag broadcast port wakes waiting operands. Every cycle the queue offers the oldest instruction whose two sources are both ready. Instructions therefore leave in any order, while waiting instructions stay in the queue.

Storage is kept compacted. When an instruction leaves, every younger entry moves one slot toward the head. Slot index then always matches age, so the select is a fixed lowest-index-first priority encoder. The slot freed by an issue can take a new instruction in the same cycle.

Both data interfaces use valid/ready. The input is accepted on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is the inverse of `full`. The output transfers on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, nothing leaves the queue and `out_valid` stays high. The offered instruction can still change to an older one that has just become eligible.

Top module: `iq_wakeup_select`

## Requirements
- R1: After reset the queue is empty: `out_valid` is 0, `full` is 0 and `in_ready` is 1.
- R2: An instruction is stored when `in_valid` and `in_ready` are both high. Stored instructions keep their arrival order as age order.
- R3: When `bc_valid` is high, every stored source whose ready flag is clear and whose tag equals `bc_tag` becomes ready. An instruction is offered only when both of its sources are ready.
- R4: An instruction accepted in the same cycle as a broadcast that matches one of its sources stores that source as ready.
- R5: An entry made eligible by a broadcast in cycle N is offered no earlier than cycle N+1.
- R6: Among all eligible entries, the one offered on the output is the oldest.
- R7: While `out_valid` is high and `out_ready` is low, nothing leaves the queue and `out_valid` stays high in the next cycle.
- R8: `full` is high when all 8 slots hold an instruction and no instruction leaves in that cycle. `in_ready` equals the inverse of `full`. An input offered while `full` is high is not stored.
- R9: `out_dst_tag` and `out_op` carry the destination tag and operation field of the offered entry.
- R10: An entry that is not eligible stays in the queue until it becomes eligible and issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming instruction valid |
| in_ready | output | 1 | Queue can accept an instruction (inverse of full) |
| in_s1_tag | input | 6 | First source tag |
| in_s1_rdy | input | 1 | First source already ready |
| in_s2_tag | input | 6 | Second source tag |
| in_s2_rdy | input | 1 | Second source already ready |
| in_dst_tag | input | 6 | Destination tag |
| in_op | input | 8 | Operation field carried unchanged |
| bc_valid | input | 1 | Result tag broadcast valid |
| bc_tag | input | 6 | Broadcast result tag |
| out_valid | output | 1 | An eligible instruction is offered |
| out_ready | input | 1 | Consumer takes the offered instruction |
| out_dst_tag | output | 6 | Destination tag of offered instruction |
| out_op | output | 8 | Operation field of offered instruction |
| full | output | 1 | All slots occupied and none leaving this cycle |

## Verification
A missed or spurious wakeup shows up at the output one cycle after the broadcast. Either `out_valid` rises when it should not, or an instruction that should issue never appears. A fault in the compaction shifter breaks the age order. The next output transfer then carries the wrong destination tag or operation, often several instructions after the faulty shift. An occupancy count that drifts shows at `full` and `in_ready` the next time the queue fills or drains. A bench model that tracks every entry exposes each of these faults at the first divergent cycle.

// File: rtl/iqws_pkg.sv
package iqws_pkg;
  parameter int TAG_W = 6;
  parameter int OP_W  = 8;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [TAG_W-1:0] dst;
    logic [TAG_W-1:0] s1;
    logic             r1;
    logic [TAG_W-1:0] s2;
    logic             r2;
  } iq_ent_t;
endpackage

// File: rtl/iqws_wake.sv
module iqws_wake
  import iqws_pkg::*;
(
  input  logic             bc_valid,
  input  logic [TAG_W-1:0] bc_tag,
  input  iq_ent_t          ent_i,
  output iq_ent_t          ent_o
);
  always_comb begin
    ent_o = ent_i;
    if (bc_valid && !ent_i.r1 && (ent_i.s1 == bc_tag)) ent_o.r1 = 1'b1;
    if (bc_valid && !ent_i.r2 && (ent_i.s2 == bc_tag)) ent_o.r2 = 1'b1;
  end
endmodule

// File: rtl/iqws_pick.sv
module iqws_pick #(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] elig,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  // R3
  pick_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> elig[idx]);

  // R6
  pick_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((elig & ((DEPTH'(1) << idx) - DEPTH'(1))) == '0));
endmodule

// File: rtl/iqws_compact.sv
module iqws_compact
  import iqws_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  iq_ent_t          cur [DEPTH],
  input  logic             pop,
  input  logic [IDX_W-1:0] pop_idx,
  input  logic             push,
  input  logic [CNT_W-1:0] push_pos,
  input  iq_ent_t          push_ent,
  output iq_ent_t          nxt [DEPTH]
);
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_comb begin
        nxt[g] = cur[g];
        if (g < DEPTH - 1) begin
          if (pop && (IDX_W'(g) >= pop_idx)) nxt[g] = cur[(g < DEPTH - 1) ? g + 1 : g];
        end
        if (push && (push_pos == CNT_W'(g))) nxt[g] = push_ent;
      end
    end
  endgenerate
endmodule

// File: rtl/iq_wakeup_select.sv
module iq_wakeup_select
  import iqws_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [TAG_W-1:0] in_s1_tag,
  input  logic             in_s1_rdy,
  input  logic [TAG_W-1:0] in_s2_tag,
  input  logic             in_s2_rdy,
  input  logic [TAG_W-1:0] in_dst_tag,
  input  logic [OP_W-1:0]  in_op,
  input  logic             bc_valid,
  input  logic [TAG_W-1:0] bc_tag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [TAG_W-1:0] out_dst_tag,
  output logic [OP_W-1:0]  out_op,
  output logic             full
);
  iq_ent_t          ent_q   [DEPTH];
  iq_ent_t          ent_wk  [DEPTH];
  iq_ent_t          ent_nxt [DEPTH];
  iq_ent_t          new_raw;
  iq_ent_t          new_wk;
  logic [CNT_W-1:0] cnt_q;
  logic [DEPTH-1:0] elig;
  logic             any;
  logic [IDX_W-1:0] sel;
  logic             pop;
  logic             push;
  logic [CNT_W-1:0] push_pos;

  // Incoming instruction, woken by the same-cycle broadcast.
  always_comb begin
    new_raw.op  = in_op;
    new_raw.dst = in_dst_tag;
    new_raw.s1  = in_s1_tag;
    new_raw.r1  = in_s1_rdy;
    new_raw.s2  = in_s2_tag;
    new_raw.r2  = in_s2_rdy;
  end

  iqws_wake u_wake_in (
    .bc_valid (bc_valid),
    .bc_tag   (bc_tag),
    .ent_i    (new_raw),
    .ent_o    (new_wk)
  );

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      iqws_wake u_wake (
        .bc_valid (bc_valid),
        .bc_tag   (bc_tag),
        .ent_i    (ent_q[g]),
        .ent_o    (ent_wk[g])
      );
      // Eligibility uses stored flags only: a wakeup counts from the next cycle.
      assign elig[g] = (CNT_W'(g) < cnt_q) && ent_q[g].r1 && ent_q[g].r2;
    end
  endgenerate

  iqws_pick #(.DEPTH(DEPTH)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .elig  (elig),
    .any   (any),
    .idx   (sel)
  );

  assign out_valid   = any;
  assign out_dst_tag = ent_q[sel].dst;
  assign out_op      = ent_q[sel].op;
  assign pop         = any && out_ready;
  assign full        = (cnt_q == CNT_W'(DEPTH)) && !pop;
  assign in_ready    = !full;
  assign push        = in_valid && !full;
  assign push_pos    = cnt_q - CNT_W'(pop);

  iqws_compact #(.DEPTH(DEPTH)) u_compact (
    .cur      (ent_wk),
    .pop      (pop),
    .pop_idx  (sel),
    .push     (push),
    .push_pos (push_pos),
    .push_ent (new_wk),
    .nxt      (ent_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      cnt_q <= cnt_q - CNT_W'(pop) + CNT_W'(push);
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_nxt[i];
    end
  end

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R2
  count_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'($past(push)) - CNT_W'($past(pop)))));

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> (cnt_q == CNT_W'(DEPTH)));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
endmodule

// File: tb/iq_wakeup_select_bench.sv
`timescale 1ns/1ps
module iq_wakeup_select_bench;
  localparam int MD = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [5:0] in_s1_tag = '0;
  logic       in_s1_rdy = 1'b0;
  logic [5:0] in_s2_tag = '0;
  logic       in_s2_rdy = 1'b0;
  logic [5:0] in_dst_tag = '0;
  logic [7:0] in_op = '0;
  logic       bc_valid = 1'b0;
  logic [5:0] bc_tag = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [5:0] out_dst_tag;
  logic [7:0] out_op;
  logic       full;

  always #2 clk = ~clk;

  iq_wakeup_select u_iq_wakeup_select (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_s1_tag(in_s1_tag), .in_s1_rdy(in_s1_rdy),
    .in_s2_tag(in_s2_tag), .in_s2_rdy(in_s2_rdy),
    .in_dst_tag(in_dst_tag), .in_op(in_op),
    .bc_valid(bc_valid), .bc_tag(bc_tag),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_dst_tag(out_dst_tag), .out_op(out_op), .full(full)
  );

  int vectors = 0;
  int errors  = 0;

  // Reference model of the queue contents, index 0 oldest.
  logic [5:0] m_s1 [MD];
  logic       m_r1 [MD];
  logic [5:0] m_s2 [MD];
  logic       m_r2 [MD];
  logic [5:0] m_dst [MD];
  logic [7:0] m_op [MD];
  int         m_cnt = 0;

  task automatic chk(input logic act, input logic exp, input string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic chk_w(input logic [7:0] act, input logic [7:0] exp, input string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic int oldest_ready();
    for (int i = 0; i < m_cnt; i++)
      if (m_r1[i] && m_r2[i]) return i;
    return -1;
  endfunction

  // Compare outputs with the model, then advance the model by one cycle.
  task automatic compare_and_advance();
    int  s;
    bit  e_iv, fire, e_full, ins;
    s      = oldest_ready();
    e_iv   = (s >= 0);
    fire   = e_iv && out_ready;
    e_full = (m_cnt == MD) && !fire;
    ins    = in_valid && !e_full;
    chk(out_valid, e_iv, "R3 R4 R5 R10 out_valid");
    if (e_iv) begin
      chk_w({2'b00, out_dst_tag}, {2'b00, m_dst[s]}, "R6 R7 R9 out_dst_tag");
      chk_w(out_op, m_op[s], "R2 R6 R9 out_op");
    end
    chk(full, e_full, "R8 full");
    chk(in_ready, !e_full, "R8 in_ready");
    for (int i = 0; i < m_cnt; i++) begin
      if (bc_valid && !m_r1[i] && m_s1[i] == bc_tag) m_r1[i] = 1'b1;
      if (bc_valid && !m_r2[i] && m_s2[i] == bc_tag) m_r2[i] = 1'b1;
    end
    if (fire) begin
      for (int i = s; i < MD - 1; i++) begin
        m_s1[i] = m_s1[i+1]; m_r1[i] = m_r1[i+1];
        m_s2[i] = m_s2[i+1]; m_r2[i] = m_r2[i+1];
        m_dst[i] = m_dst[i+1]; m_op[i] = m_op[i+1];
      end
      m_cnt--;
    end
    if (ins) begin
      m_s1[m_cnt]  = in_s1_tag;
      m_r1[m_cnt]  = in_s1_rdy || (bc_valid && in_s1_tag == bc_tag);
      m_s2[m_cnt]  = in_s2_tag;
      m_r2[m_cnt]  = in_s2_rdy || (bc_valid && in_s2_tag == bc_tag);
      m_dst[m_cnt] = in_dst_tag;
      m_op[m_cnt]  = in_op;
      m_cnt++;
    end
  endtask

  task automatic cyc(input bit iv, input logic [5:0] t1, input bit r1,
                     input logic [5:0] t2, input bit r2, input logic [5:0] d,
                     input logic [7:0] op, input bit bv, input logic [5:0] bt,
                     input bit ordy);
    @(negedge clk);
    in_valid = iv; in_s1_tag = t1; in_s1_rdy = r1; in_s2_tag = t2; in_s2_rdy = r2;
    in_dst_tag = d; in_op = op; bc_valid = bv; bc_tag = bt; out_ready = ordy;
    #1;
    compare_and_advance();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : stim
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(out_valid, 1'b0, "R1 out_valid after reset");
    chk(full, 1'b0, "R1 full after reset");
    chk(in_ready, 1'b1, "R1 in_ready after reset");

    // Fill with entries waiting on tags 1..8; none eligible (R10).
    for (int i = 0; i < MD; i++)
      cyc(1, 6'(i + 1), 0, 6'd0, 1, 6'(i), 8'(8'h10 + i), 0, 0, 1);
    // Queue full: insertion refused (R8).
    cyc(1, 6'd40, 1, 6'd41, 1, 6'd50, 8'hEE, 0, 0, 1);
    // Wake the youngest: not offered this cycle (R5), offered next.
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 6'd8, 0);
    // Stall the output while full (R7, R8).
    cyc(1, 6'd40, 1, 6'd41, 1, 6'd51, 8'hE1, 0, 0, 0);
    cyc(1, 6'd40, 1, 6'd41, 1, 6'd52, 8'hE2, 0, 0, 0);
    // Release: issue frees a slot in the same cycle, insertion accepted (R8).
    cyc(1, 6'd33, 0, 6'd0, 1, 6'd53, 8'hE3, 0, 0, 1);
    // Same-cycle capture of a wakeup on insertion (R4).
    cyc(1, 6'd34, 0, 6'd35, 1, 6'd54, 8'hE4, 1, 6'd34, 1);
    // Two wake out of order; the older must go first (R6).
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 6'd3, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 6'd2, 0);
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // Drain the rest.
    for (int t = 1; t < 40; t++) cyc(0, 0, 0, 0, 0, 0, 0, 1, 6'(t), 1);

    // Constrained random phase.
    for (int n = 0; n < 4000; n++) begin
      cyc(($urandom % 4) != 0,
          6'($urandom % 12), ($urandom % 2) == 0,
          6'($urandom % 12), ($urandom % 2) == 0,
          6'($urandom % 64), 8'($urandom % 256),
          ($urandom % 3) != 0, 6'($urandom % 12),
          ($urandom % 4) != 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule